// File: doc/BRIEF.md
# Shadow RAM Region Attribute Decoder

This block decides, for every CPU memory access in the first megabyte, where the access is served and what it may do. It serves the memory-map control of an early PC memory controller. Software programs a handful of 16-bit configuration registers through a byte-addressed I/O port. The decoder then classifies each address from `mem_addr` and `mem_wr` with no clock delay. It reports whether the access goes to local DRAM, whether writes into the region are refused, and whether the system-ROM shadow applies to the access.

There are two ways to describe the upper memory area. In coarse mode, fixed 128KB blocks follow single bits of the memory-control register. In extended mode, the top 256KB is cut into eight 32KB segments, and each segment has its own enable and read-only bit. A ROM-size bit moves the start of the system ROM window. A lock bit in the memory-control register freezes every register until reset.

Top module: `shadow_map_decoder`

## Requirements
- R1: After reset every register reads 0, extended mode is off, 0x80000-0x9FFFF decodes as disabled (route_local=0, write_blocked=1), and 0xA0000-0xFFFFF decodes as external (route_local=0, write_blocked=0).
- R2: Any address below 0x80000 decodes as local read-write (route_local=1, write_blocked=0) in every configuration.
- R3: Register 0x22 bit 3 set maps 0x80000-0x9FFFF as local read-write. When the bit is clear, that range is disabled (route_local=0, write_blocked=1). This holds in both modes.
- R4: For 0xA0000-0xBFFFF, register 0x22 bit 10 clear means external. Bit 10 set with bit 11 set means local read-write. Bit 10 set with bit 11 clear means read-only: route_local=1 on reads, route_local=0 on writes, and write_blocked=1. This holds in both modes.
- R5: In coarse mode, register 0x22 bit 9 set makes 0xC0000-0xDFFFF local read-write. Clear makes it external.
- R6: In coarse mode, register 0x22 bit 0 set makes 0xE0000-0xFFFFF local read-write and sets both BIOS shadow flags. Clear makes the range external and clears both flags.
- R7: Register 0x2C bit 0 selects extended mode. Segment k (0..7) covers 0xC0000+k*0x8000 for 32KB. Register 0x2E bit 8+k enables the segment and bit k makes it read-only. A segment that is not enabled is external. Read-only follows the encoding of R4.
- R8: The ROM window starts at 0xE0000 when register 0x22 bit 8 is 1, and at 0xF0000 when it is 0, and runs to 0xFFFFF. bios_shadow_active is 1 only inside the window, and then equals the read flag on reads and the write flag on writes. In extended mode, the read flag is the enable bit, and the write flag is the read-only bit, of the segment that starts at the window base.
- R9: Once a write leaves register 0x22 bit 15 at 1, all later register writes are ignored until reset. Reads still return the held values.
- R10: Registers 0x22, 0x28, 0x2A, 0x2C and 0x2E read back the last accepted value. Every other port reads 0 and ignores writes. A write changes the decode from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | Register write strobe |
| io_addr | input | 8 | Register port number for reads and writes |
| io_wdata | input | 16 | Register write data |
| io_rdata | output | 16 | Register read data for io_addr, combinational |
| mem_addr | input | 20 | CPU memory access address |
| mem_wr | input | 1 | 1 for a write access, 0 for a read |
| route_local | output | 1 | Access is served by local DRAM |
| write_blocked | output | 1 | Region refuses writes |
| bios_shadow_active | output | 1 | System-ROM shadow applies to this access |

## Verification
The properties assume that `mem_addr` and `mem_wr` are stable around each rising clock edge, because the decode is sampled there. They also assume that `io_we` is a clean one-cycle level with a steady address and data. The bench changes every input on the falling edge only. It lets the combinational decode settle before it reads the outputs. It issues each register write as a single strobe that spans exactly one rising edge.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int CFG_W      = 16;
  localparam int PORT_W     = 8;
  localparam int MEM_AW     = 20;
  localparam int SEG_COUNT  = 8;
  localparam int SEG_IDX_W  = $clog2(SEG_COUNT);
  localparam int NREG       = 5;
  localparam int SLOT_W     = 3;
  localparam int LOCK_BIT   = 15;

  localparam logic [PORT_W-1:0] P_MEMCTL = 8'h22;
  localparam logic [PORT_W-1:0] P_AUX0   = 8'h28;
  localparam logic [PORT_W-1:0] P_AUX1   = 8'h2A;
  localparam logic [PORT_W-1:0] P_GRAN   = 8'h2C;
  localparam logic [PORT_W-1:0] P_SEG    = 8'h2E;

  localparam logic [SLOT_W-1:0] SLOT_NONE = 3'd7;

  localparam logic [MEM_AW-1:0] UPPER_BASE = 20'hC0000;
  localparam logic [MEM_AW-1:0] ROM_BIG    = 20'hE0000;
  localparam logic [MEM_AW-1:0] ROM_SMALL  = 20'hF0000;

  typedef enum logic [1:0] {
    ATTR_EXT = 2'd0,
    ATTR_RW  = 2'd1,
    ATTR_RO  = 2'd2,
    ATTR_OFF = 2'd3
  } attr_t;

  function automatic logic [SLOT_W-1:0] port_slot(input logic [PORT_W-1:0] a);
    case (a)
      P_MEMCTL: return 3'd0;
      P_AUX0:   return 3'd1;
      P_AUX1:   return 3'd2;
      P_GRAN:   return 3'd3;
      P_SEG:    return 3'd4;
      default:  return SLOT_NONE;
    endcase
  endfunction

  function automatic attr_t coarse_attr(input logic [CFG_W-1:0] mc, input logic [2:0] blk);
    case (blk)
      3'd4:    return mc[3] ? ATTR_RW : ATTR_OFF;
      3'd5:    return mc[10] ? (mc[11] ? ATTR_RW : ATTR_RO) : ATTR_EXT;
      3'd6:    return mc[9] ? ATTR_RW : ATTR_EXT;
      3'd7:    return mc[0] ? ATTR_RW : ATTR_EXT;
      default: return ATTR_RW;
    endcase
  endfunction

  function automatic attr_t seg_attr_of(input logic en, input logic ro);
    if (!en) return ATTR_EXT;
    return ro ? ATTR_RO : ATTR_RW;
  endfunction

  function automatic logic [MEM_AW-1:0] rom_base_of(input logic [CFG_W-1:0] mc);
    return mc[8] ? ROM_BIG : ROM_SMALL;
  endfunction

  function automatic logic [SEG_IDX_W-1:0] rom_seg_of(input logic [CFG_W-1:0] mc);
    return mc[8] ? 3'd4 : 3'd6;
  endfunction
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [PORT_W-1:0] io_addr,
  input  logic [CFG_W-1:0]  io_wdata,
  output logic [CFG_W-1:0]  io_rdata,
  output logic [CFG_W-1:0]  mem_ctl,
  output logic [CFG_W-1:0]  gran_ctl,
  output logic [CFG_W-1:0]  seg_ctl,
  output logic              cfg_locked,
  output logic              wr_accept
);
  logic [CFG_W-1:0]  regs [NREG];
  logic [SLOT_W-1:0] slot;
  logic              slot_ok;

  assign slot       = port_slot(io_addr);
  assign slot_ok    = (slot != SLOT_NONE);
  assign cfg_locked = regs[0][LOCK_BIT];
  assign wr_accept  = io_we && slot_ok && !cfg_locked;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[r] <= '0;
      else if (wr_accept && slot == SLOT_W'(r))
        regs[r] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (slot_ok) io_rdata = regs[slot];
  end

  assign mem_ctl  = regs[0];
  assign gran_ctl = regs[3];
  assign seg_ctl  = regs[4];
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
#(
  parameter int NSEG  = SEG_COUNT,
  parameter int IDX_W = $clog2(NSEG)
) (
  input  logic [2*NSEG-1:0] seg_ctl,
  input  logic [IDX_W-1:0]  seg_idx,
  input  logic [IDX_W-1:0]  rom_idx,
  output attr_t             seg_attr,
  output logic              rom_en,
  output logic              rom_ro
);
  attr_t attrs [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign attrs[g] = seg_attr_of(seg_ctl[NSEG+g], seg_ctl[g]);
  end

  assign seg_attr = attrs[seg_idx];
  assign rom_en   = seg_ctl[NSEG + int'(rom_idx)];
  assign rom_ro   = seg_ctl[rom_idx];
endmodule

// File: rtl/shadow_coarse_decode.sv
module shadow_coarse_decode
  import shadow_pkg::*;
(
  input  logic [CFG_W-1:0] mem_ctl,
  input  logic [2:0]       blk,
  output attr_t            attr,
  output logic             bios_flag
);
  assign attr      = coarse_attr(mem_ctl, blk);
  assign bios_flag = (coarse_attr(mem_ctl, 3'd7) == ATTR_RW);
endmodule

// File: rtl/shadow_map_decoder.sv
module shadow_map_decoder
  import shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [PORT_W-1:0] io_addr,
  input  logic [CFG_W-1:0]  io_wdata,
  output logic [CFG_W-1:0]  io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_wr,
  output logic              route_local,
  output logic              write_blocked,
  output logic              bios_shadow_active
);
  localparam int BLK_LSB = MEM_AW - 3;
  localparam int SEG_LSB = BLK_LSB - SEG_IDX_W;

  logic [CFG_W-1:0] mem_ctl, gran_ctl, seg_ctl;
  logic             cfg_locked, wr_accept;
  logic             ext_mode, in_upper, in_rom_win;
  attr_t            c_attr, s_attr, sel_attr;
  logic             c_bios, rom_en, rom_ro;
  logic             bios_rd_flag, bios_wr_flag;

  shadow_cfg_regs i_regs (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_ctl(mem_ctl),
    .gran_ctl(gran_ctl), .seg_ctl(seg_ctl), .cfg_locked(cfg_locked),
    .wr_accept(wr_accept)
  );

  shadow_coarse_decode i_coarse (
    .mem_ctl(mem_ctl), .blk(mem_addr[MEM_AW-1:BLK_LSB]),
    .attr(c_attr), .bios_flag(c_bios)
  );

  shadow_seg_decode #(.NSEG(SEG_COUNT)) i_seg (
    .seg_ctl(seg_ctl), .seg_idx(mem_addr[BLK_LSB:SEG_LSB+1]),
    .rom_idx(rom_seg_of(mem_ctl)), .seg_attr(s_attr),
    .rom_en(rom_en), .rom_ro(rom_ro)
  );

  assign ext_mode   = gran_ctl[0];
  assign in_upper   = (mem_addr >= UPPER_BASE);
  assign in_rom_win = (mem_addr >= rom_base_of(mem_ctl));
  assign sel_attr   = (ext_mode && in_upper) ? s_attr : c_attr;

  assign bios_rd_flag = ext_mode ? rom_en : c_bios;
  assign bios_wr_flag = ext_mode ? rom_ro : c_bios;

  assign route_local   = (sel_attr == ATTR_RW) || (sel_attr == ATTR_RO && !mem_wr);
  assign write_blocked = (sel_attr == ATTR_RO) || (sel_attr == ATTR_OFF);
  assign bios_shadow_active = in_rom_win && (mem_wr ? bios_wr_flag : bios_rd_flag);
endmodule

// File: rtl/shadow_map_checker.sv
module shadow_map_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_we,
  input logic [7:0]  io_addr,
  input logic [15:0] io_wdata,
  input logic [19:0] mem_addr,
  input logic        mem_wr,
  input logic        route_local,
  input logic        write_blocked,
  input logic        bios_shadow_active,
  input logic [15:0] mem_ctl,
  input logic [15:0] gran_ctl,
  input logic [15:0] seg_ctl,
  input logic        cfg_locked
);
  assert_low_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < 20'h80000) |-> (route_local && !write_blocked));

  assert_video_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr >= 20'hA0000 && mem_addr < 20'hC0000 && !mem_ctl[10])
      |-> (!route_local && !write_blocked));

  assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (write_blocked && mem_wr) |-> !route_local);

  assert_bios_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bios_shadow_active |-> (mem_addr >= 20'hE0000));

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && io_we) |=> ($stable(mem_ctl) && $stable(gran_ctl) && $stable(seg_ctl)));

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && !cfg_locked && io_addr == 8'h22) |=> (mem_ctl == $past(io_wdata)));
endmodule

bind shadow_map_decoder shadow_map_checker i_chk (
  .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
  .io_wdata(io_wdata), .mem_addr(mem_addr), .mem_wr(mem_wr),
  .route_local(route_local), .write_blocked(write_blocked),
  .bios_shadow_active(bios_shadow_active), .mem_ctl(mem_ctl),
  .gran_ctl(gran_ctl), .seg_ctl(seg_ctl), .cfg_locked(cfg_locked)
);

// File: tb/test_shadow_map_decoder.sv
module test_shadow_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_we = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic [19:0] mem_addr = '0;
  logic        mem_wr = 1'b0;
  logic        route_local, write_blocked, bios_shadow_active;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_mc = '0, m_aux0 = '0, m_aux1 = '0, m_gran = '0, m_seg = '0;
  bit m_lock = 0;

  always #10 clk = ~clk;

  shadow_map_decoder i_shadow_map_decoder (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .route_local(route_local), .write_blocked(write_blocked),
    .bios_shadow_active(bios_shadow_active)
  );

  function automatic logic [2:0] model(input logic [19:0] a, input logic w);
    logic loc, blk, bio, en, ro, win, flag;
    int k, rk;
    logic [19:0] romb;
    loc = 0; blk = 0;
    if (a < 20'h80000) loc = 1;
    else if (a < 20'hA0000) begin loc = m_mc[3]; blk = !m_mc[3]; end
    else if (a < 20'hC0000) begin
      if (m_mc[10]) begin
        if (m_mc[11]) loc = 1; else begin loc = !w; blk = 1; end
      end
    end else if (m_gran[0]) begin
      k = int'((a - 20'hC0000) / 20'h8000);
      en = m_seg[8+k]; ro = m_seg[k];
      if (en && !ro) loc = 1;
      if (en && ro) begin loc = !w; blk = 1; end
    end else if (a < 20'hE0000) loc = m_mc[9];
    else loc = m_mc[0];
    romb = m_mc[8] ? 20'hE0000 : 20'hF0000;
    win = (a >= romb);
    if (m_gran[0]) begin
      rk = int'((romb - 20'hC0000) / 20'h8000);
      flag = w ? m_seg[rk] : m_seg[8+rk];
    end else flag = m_mc[0];
    bio = win && flag;
    return {loc, blk, bio};
  endfunction

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic probe(input logic [19:0] a, input logic w, input string rq);
    @(negedge clk);
    mem_addr = a; mem_wr = w;
    #2;
    check(rq, $sformatf("decode @%h wr=%0b", a, w),
          {29'd0, route_local, write_blocked, bios_shadow_active}, {29'd0, model(a, w)});
  endtask

  task automatic sweep(input string rq);
    for (int i = 0; i < 32; i++) begin
      for (int w = 0; w < 2; w++) begin
        probe(20'(i * 32'h8000), w[0], rq);
        probe(20'(i * 32'h8000 + 32'h7FFF), w[0], rq);
      end
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    io_we = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 0;
    if (!m_lock) begin
      case (a)
        8'h22: begin m_mc = d; m_lock = d[15]; end
        8'h28: m_aux0 = d;
        8'h2A: m_aux1 = d;
        8'h2C: m_gran = d;
        8'h2E: m_seg = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [15:0] mirror(input logic [7:0] a);
    case (a)
      8'h22: return m_mc;
      8'h28: return m_aux0;
      8'h2A: return m_aux1;
      8'h2C: return m_gran;
      8'h2E: return m_seg;
      default: return 16'h0;
    endcase
  endfunction

  task automatic readback(input logic [7:0] a, input string rq);
    @(negedge clk);
    io_addr = a;
    #2;
    check(rq, $sformatf("read port %h", a), {16'd0, io_rdata}, {16'd0, mirror(a)});
  endtask

  task automatic t_reset;
    readback(8'h22, "R1"); readback(8'h28, "R1"); readback(8'h2A, "R1");
    readback(8'h2C, "R1"); readback(8'h2E, "R1");
    probe(20'h80000, 0, "R1");
    probe(20'h90000, 1, "R1");
    probe(20'hA0000, 0, "R1");
    probe(20'hFFFFF, 1, "R1");
    sweep("R1");
  endtask

  task automatic t_low;
    io_write(8'h22, 16'h0F0F);
    io_write(8'h2C, 16'h0001);
    probe(20'h00000, 1, "R2"); probe(20'h7FFFF, 0, "R2"); probe(20'h40000, 1, "R2");
    io_write(8'h2C, 16'h0000);
    io_write(8'h22, 16'h0000);
  endtask

  task automatic t_base;
    io_write(8'h22, 16'h0008); sweep("R3");
    io_write(8'h22, 16'h0000); probe(20'h9FFFF, 1, "R3");
  endtask

  task automatic t_video;
    io_write(8'h22, 16'h0400); sweep("R4");
    io_write(8'h22, 16'h0C00); sweep("R4");
    io_write(8'h22, 16'h0800); probe(20'hB0000, 1, "R4");
  endtask

  task automatic t_option;
    io_write(8'h22, 16'h0200); sweep("R5");
  endtask

  task automatic t_sysrom;
    io_write(8'h22, 16'h0001); sweep("R6");
    io_write(8'h22, 16'h0101); sweep("R6");
    io_write(8'h22, 16'h0300); sweep("R6");
  endtask

  task automatic t_extended;
    io_write(8'h22, 16'h0C0B);
    io_write(8'h2C, 16'h0001);
    io_write(8'h2E, 16'hF00F); sweep("R7");
    io_write(8'h2E, 16'hA5C3); sweep("R7");
    io_write(8'h2E, 16'h0000); sweep("R7");
    io_write(8'h2E, 16'hFFFF); sweep("R7");
  endtask

  task automatic t_romsize;
    io_write(8'h2C, 16'h0001);
    io_write(8'h22, 16'h0100);
    io_write(8'h2E, 16'h1010); sweep("R8");
    io_write(8'h2E, 16'h1040); sweep("R8");
    io_write(8'h22, 16'h0000); sweep("R8");
    io_write(8'h2E, 16'h4040); sweep("R8");
    io_write(8'h2C, 16'h0000);
    io_write(8'h22, 16'h0001); sweep("R8");
  endtask

  task automatic t_readback;
    io_write(8'h28, 16'hA5A5); io_write(8'h2A, 16'h5A5A);
    io_write(8'h24, 16'hFFFF);
    readback(8'h28, "R10"); readback(8'h2A, "R10");
    readback(8'h24, "R10"); readback(8'h30, "R10"); readback(8'h2E, "R10");
    io_write(8'h22, 16'h0008);
    probe(20'h88000, 1, "R10");
  endtask

  task automatic t_lock;
    io_write(8'h2C, 16'h0001);
    io_write(8'h2E, 16'h3C0C);
    io_write(8'h22, 16'h8209);
    io_write(8'h22, 16'h0400);
    io_write(8'h2C, 16'h0000);
    io_write(8'h2E, 16'hFFFF);
    io_write(8'h28, 16'h1234);
    readback(8'h22, "R9"); readback(8'h2C, "R9"); readback(8'h2E, "R9");
    readback(8'h28, "R9");
    sweep("R9");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_low();
    t_base();
    t_video();
    t_option();
    t_sysrom();
    t_extended();
    t_romsize();
    t_readback();
    t_lock();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule